// File: doc/BRIEF.md
# Temperature Conversion Sequencer

This block decides when a temperature conversion runs and what the result register holds once it ends. It asks an external converter for a sample through a request and done handshake. It keeps an 8-bit configuration register that holds the resolution, a shutdown bit and a one-shot trigger. It times each conversion to the length that matches the selected resolution. At the end of each conversion it publishes a 12-bit two's-complement temperature of 0.0625 °C per LSB, so 0x190 is 25 °C and 0xE70 is -25 °C. Alert logic downstream takes the temperature value and a one-cycle result strobe.

There are three ways to run it. In continuous mode, conversions follow each other with no gap. Shutdown lets the conversion already running finish, then stops. While shut down, a one-shot write runs one conversion and then goes idle again. A conversion ends when its timed period has passed and the converter has reported done. If the converter is late, the block waits for done.

Top module: `tsq_seq`

## Requirements
- R1: While reset is asserted, the temperature register, the configuration readback, busy, the request and the strobe are all zero. On the first cycle after reset a conversion starts, in continuous mode at 9-bit resolution.
- R2: The resolution field is configuration bits [2:1]: code 0 selects 9 bits, 1 selects 10, 2 selects 11 and 3 selects 12. With the converter answering in time, a conversion lasts CONV_CYC_9, CONV_CYC_10, CONV_CYC_11 or CONV_CYC_12 clock cycles respectively, counted from the request pulse to the result strobe.
- R3: The published value is the converter sample with its 3, 2, 1 or 0 lowest bits cleared, for codes 0, 1, 2 and 3.
- R4: The resolution is captured when a conversion starts. A change written during a conversion applies from the next conversion onward.
- R5: When shutdown (configuration bit 0) is 0, a new request is issued in the same cycle as the result strobe of the previous conversion.
- R6: Writing shutdown = 1 lets the current conversion finish. After that, busy is low and no request is issued while shutdown stays set.
- R7: While the block is idle in shutdown, a write with one-shot (bit 7) = 1 and shutdown = 1 runs exactly one conversion and then returns to idle.
- R8: A one-shot write while a conversion is running has no effect. Bit 7 always reads back as 0. Bits 6:0 read back as written.
- R9: The strobe is high for exactly one cycle per completed conversion. The temperature register changes only in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration readback (bit 7 reads 0) |
| adc_req | output | 1 | One-cycle pulse that starts a converter sample |
| adc_done | input | 1 | Converter sample valid |
| adc_sample | input | 12 | Converter sample, two's complement |
| temp_q | output | 12 | Temperature register |
| busy | output | 1 | A conversion is in progress |
| result_stb | output | 1 | One-cycle pulse when temp_q is updated |

## Verification
A corrupted captured resolution shows up at the next strobe in two ways: the request-to-strobe interval is wrong, and the wrong number of low bits is cleared. A wrong conversion counter moves the strobe cycle, and the scoreboard's interval check sees this on the first conversion after reset. A wrong shutdown or idle decision shows within a single conversion period. Either a request appears during a long quiet window, or back-to-back mode loses the request that should coincide with the strobe.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
  localparam int TEMP_W  = 12;
  localparam int CFG_W   = 8;
  localparam int SD_BIT  = 0;
  localparam int RES_LO  = 1;
  localparam int OS_BIT  = 7;
  localparam int MAX_DROP = 3;

  typedef logic [1:0] res_t;

  // number of low result bits cleared for a resolution code
  function automatic logic [1:0] drop_of(input res_t r);
    return 2'(MAX_DROP) - r;
  endfunction
endpackage

// File: rtl/tsq_cfg_reg.sv
module tsq_cfg_reg
  import tsq_pkg::*;
#(
  parameter int W = CFG_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cfg_q,
  output logic         os_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (wr) begin
      cfg_q         <= wdata;
      cfg_q[OS_BIT] <= 1'b0;
    end
  end

  // one-shot is an action, not stored state
  assign os_req = wr & wdata[OS_BIT];
endmodule

// File: rtl/tsq_conv_timer.sv
module tsq_conv_timer
  import tsq_pkg::*;
#(
  parameter int C9  = 24,
  parameter int C10 = 48,
  parameter int C11 = 96,
  parameter int C12 = 192
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  res_t res_in,
  output res_t res_q,
  output logic last
);
  localparam int CMAX = (C12 > C11 ? (C12 > C10 ? (C12 > C9 ? C12 : C9) : C10) : C11);
  localparam int CW   = $clog2(CMAX + 1);

  function automatic int per_of(input int code);
    case (code)
      0:       return C9;
      1:       return C10;
      2:       return C11;
      default: return C12;
    endcase
  endfunction

  logic [CW-1:0] lim [4];
  logic [CW-1:0] cnt;

  for (genvar gi = 0; gi < 4; gi++) begin : g_lim
    assign lim[gi] = CW'(per_of(gi) - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      res_q <= '0;
    end else if (start) begin
      cnt   <= '0;
      res_q <= res_in;
    end else if (cnt != lim[res_q]) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign last = (cnt == lim[res_q]);
endmodule

// File: rtl/tsq_result_reg.sv
module tsq_result_reg
  import tsq_pkg::*;
#(
  parameter int W = TEMP_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap,
  input  logic [W-1:0] sample,
  input  logic         publish,
  input  res_t         res,
  output logic [W-1:0] temp_q,
  output logic         stb
);
  logic [W-1:0] hold;
  logic [W-1:0] src;
  logic [W-1:0] keep;
  logic [1:0]   drop;

  assign drop = drop_of(res);
  assign src  = cap ? sample : hold;

  for (genvar bi = 0; bi < W; bi++) begin : g_keep
    if (bi >= MAX_DROP) begin : g_fixed
      assign keep[bi] = 1'b1;
    end else begin : g_sel
      assign keep[bi] = (2'(bi) >= drop);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold   <= '0;
      temp_q <= '0;
      stb    <= 1'b0;
    end else begin
      stb <= publish;
      if (cap)     hold   <= sample;
      if (publish) temp_q <= src & keep;
    end
  end
endmodule

// File: rtl/tsq_seq.sv
module tsq_seq
  import tsq_pkg::*;
#(
  parameter int TW          = TEMP_W,
  parameter int CW8         = CFG_W,
  parameter int CONV_CYC_9  = 24,
  parameter int CONV_CYC_10 = 48,
  parameter int CONV_CYC_11 = 96,
  parameter int CONV_CYC_12 = 192
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_wr,
  input  logic [CW8-1:0] cfg_wdata,
  output logic [CW8-1:0] cfg_rdata,
  output logic           adc_req,
  input  logic           adc_done,
  input  logic [TW-1:0]  adc_sample,
  output logic [TW-1:0]  temp_q,
  output logic           busy,
  output logic           result_stb
);
  logic [CW8-1:0] cfg_q;
  logic           os_req;
  logic           sd;
  res_t           res_cfg;
  res_t           res_run;
  logic           last;
  logic           got_done;
  logic           cap;
  logic           finish;
  logic           start_now;

  tsq_cfg_reg #(.W(CW8)) u_cfg (
    .clk    (clk),
    .rst    (rst),
    .wr     (cfg_wr),
    .wdata  (cfg_wdata),
    .cfg_q  (cfg_q),
    .os_req (os_req)
  );

  assign sd        = cfg_q[SD_BIT];
  assign res_cfg   = cfg_q[RES_LO +: 2];
  assign cfg_rdata = cfg_q;

  tsq_conv_timer #(
    .C9  (CONV_CYC_9),
    .C10 (CONV_CYC_10),
    .C11 (CONV_CYC_11),
    .C12 (CONV_CYC_12)
  ) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .start  (start_now),
    .res_in (res_cfg),
    .res_q  (res_run),
    .last   (last)
  );

  assign cap    = busy & adc_done;
  assign finish = busy & last & (got_done | adc_done);

  // idle: continuous mode or a one-shot while shut down; busy: chain only if not shut down
  assign start_now = busy ? (finish & ~sd) : (~sd | os_req);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      adc_req  <= 1'b0;
      got_done <= 1'b0;
    end else begin
      adc_req <= start_now;
      if (start_now)   busy <= 1'b1;
      else if (finish) busy <= 1'b0;
      if (start_now)   got_done <= 1'b0;
      else if (cap)    got_done <= 1'b1;
    end
  end

  tsq_result_reg #(.W(TW)) u_res (
    .clk     (clk),
    .rst     (rst),
    .cap     (cap),
    .sample  (adc_sample),
    .publish (finish),
    .res     (res_run),
    .temp_q  (temp_q),
    .stb     (result_stb)
  );
endmodule

// File: rtl/tsq_seq_chk.sv
module tsq_seq_chk #(
  parameter int TW  = 12,
  parameter int CW8 = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           cfg_wr,
  input logic [CW8-1:0] cfg_rdata,
  input logic           adc_req,
  input logic           busy,
  input logic           result_stb,
  input logic [TW-1:0]  temp_q
);
  // R8: one-shot bit never reads back set
  p_os_zero_r8: assert property (@(posedge clk) disable iff (rst) !cfg_rdata[7]);

  // R9: temperature only moves together with the strobe
  p_temp_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !result_stb |-> $stable(temp_q));

  // R9: strobe lasts one cycle
  p_stb_single_r9: assert property (@(posedge clk) disable iff (rst)
    result_stb |=> !result_stb);

  // R9: a strobe closes a conversion that was running
  p_stb_in_conv_r9: assert property (@(posedge clk) disable iff (rst)
    result_stb |-> $past(busy));

  // R5: every request opens a conversion
  p_req_busy_r5: assert property (@(posedge clk) disable iff (rst)
    adc_req |-> busy);

  // R6: idle in shutdown without a write stays idle
  p_shut_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (!busy && cfg_rdata[0] && !cfg_wr) |=> !busy);
endmodule

bind tsq_seq tsq_seq_chk #(.TW(TW), .CW8(CW8)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_wr     (cfg_wr),
  .cfg_rdata  (cfg_rdata),
  .adc_req    (adc_req),
  .busy       (busy),
  .result_stb (result_stb),
  .temp_q     (temp_q)
);

// File: tb/tsq_seq_tb.sv
module tsq_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int P9 = 24, P10 = 48, P11 = 96, P12 = 192;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        adc_req;
  logic        adc_done = 1'b0;
  logic [11:0] adc_sample = '0;
  logic [11:0] temp_q;
  logic        busy;
  logic        result_stb;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int sc = 0;
  bit finished = 0;

  logic [11:0] exp_q[$];
  int          start_q[$];
  int          per_q[$];

  tsq_seq #(
    .CONV_CYC_9(P9), .CONV_CYC_10(P10), .CONV_CYC_11(P11), .CONV_CYC_12(P12)
  ) u_dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .adc_req(adc_req), .adc_done(adc_done),
    .adc_sample(adc_sample), .temp_q(temp_q), .busy(busy),
    .result_stb(result_stb)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] sample_of(input int i);
    case (i % 8)
      0: return 12'h19F;
      1: return 12'hE77;
      2: return 12'h7FF;
      3: return 12'h800;
      4: return 12'h003;
      5: return 12'hC95;
      6: return 12'h4B6;
      default: return 12'h005;
    endcase
  endfunction

  function automatic int per_of(input logic [1:0] r);
    case (r)
      2'd0: return P9;
      2'd1: return P10;
      2'd2: return P11;
      default: return P12;
    endcase
  endfunction

  // converter model plus scoreboard monitor, ordered inside one process
  logic [7:0]  prev_cfg = '0;
  logic [11:0] pending = '0;
  int          done_cd = 0;
  int          sidx = 0;
  bit          prev_stb = 0;

  always @(negedge clk) begin
    if (rst) begin
      adc_done = 1'b0;
      done_cd  = 0;
    end else begin
      // monitor
      if (result_stb) begin
        chk(!prev_stb, "R9 strobe width", 1, 0);
        if (exp_q.size() == 0) begin
          chk(0, "R9 unexpected strobe", 1, 0);
        end else begin
          logic [11:0] e;
          int s, p;
          e = exp_q.pop_front();
          s = start_q.pop_front();
          p = per_q.pop_front();
          chk(temp_q == e, "R3 R9 temperature value", temp_q, e);
          chk(cyc - s == p, "R2 R4 conversion length", cyc - s, p);
          if (prev_cfg[0] == 1'b0)
            chk(adc_req && busy, "R5 back-to-back request", adc_req, 1);
          else
            chk(!busy && !adc_req, "R6 stop after shutdown", busy, 0);
        end
        sc++;
      end
      prev_stb = result_stb;
      // converter
      adc_done = 1'b0;
      if (done_cd > 0) begin
        done_cd--;
        if (done_cd == 0) begin
          adc_done   = 1'b1;
          adc_sample = pending;
        end
      end
      if (adc_req) begin
        pending = sample_of(sidx);
        sidx++;
        exp_q.push_back(pending & (12'hFFF << (3 - prev_cfg[2:1])));
        start_q.push_back(cyc);
        per_q.push_back(per_of(prev_cfg[2:1]));
        done_cd = 2;
      end
    end
    prev_cfg = cfg_rdata;
  end

  task automatic wr_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_wr    = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_wr    = 1'b0;
  endtask

  task automatic wait_strobes(input int n);
    int target;
    target = sc + n;
    while (sc < target) @(negedge clk);
  endtask

  task automatic report();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      report();
      $finish;
    end
  end

  initial begin
    int s0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(temp_q == 0, "R1 temp at reset", temp_q, 0);
    chk(cfg_rdata == 0, "R1 cfg at reset", cfg_rdata, 0);
    chk(!busy && !adc_req && !result_stb, "R1 idle at reset", busy, 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy && adc_req, "R1 first conversion starts", busy, 1);
    chk(temp_q == 0, "R1 temp zero before first result", temp_q, 0);

    // continuous 9-bit (R2, R3, R5)
    wait_strobes(4);

    // R4: change resolution while converting
    repeat (5) @(negedge clk);
    wr_cfg(8'h06);
    chk(cfg_rdata == 8'h06, "R8 readback", cfg_rdata, 8'h06);
    wait_strobes(3);
    wr_cfg(8'h02);
    wait_strobes(2);
    wr_cfg(8'h04);
    wait_strobes(2);

    // R8 and R6: one-shot while running is ignored, shutdown finishes the current conversion
    repeat (10) @(negedge clk);
    s0 = sc;
    wr_cfg(8'h85);
    chk(cfg_rdata == 8'h05, "R8 one-shot reads zero", cfg_rdata, 8'h05);
    repeat (P11 + 600) @(negedge clk);
    chk(sc - s0 == 1, "R6 R8 single finishing conversion", sc - s0, 1);
    chk(!busy, "R6 idle after shutdown", busy, 0);

    // R7 one-shot at 9 bits
    s0 = sc;
    wr_cfg(8'h81);
    repeat (300) @(negedge clk);
    chk(sc - s0 == 1, "R7 one-shot 9-bit count", sc - s0, 1);
    chk(!busy, "R7 idle after one-shot", busy, 0);

    // R7 one-shot at 12 bits
    s0 = sc;
    wr_cfg(8'h87);
    repeat (500) @(negedge clk);
    chk(sc - s0 == 1, "R7 one-shot 12-bit count", sc - s0, 1);

    // R8 spare bits stored, no effect while shut down
    s0 = sc;
    wr_cfg(8'h79);
    repeat (100) @(negedge clk);
    chk(cfg_rdata == 8'h79, "R8 spare readback", cfg_rdata, 8'h79);
    chk(sc == s0 && !busy, "R6 spare write no conversion", sc - s0, 0);

    // resume continuous
    wr_cfg(8'h00);
    wait_strobes(3);
    chk(busy, "R5 continuous resumed", busy, 1);

    finished = 1;
    report();
    $finish;
  end
endmodule